// File: doc/BRIEF.md
# Single-Cycle Load/Store/ALU/Branch Processor Core

This block is a small 32-bit processor core that completes each instruction within one clock period. It handles a seven-instruction slice of the RV32I base set: word load, word store, register-register add, subtract, AND and OR, and branch-if-equal. On every cycle the program counter goes out on the instruction port. The fetched word is decoded, its source registers are read, and one shared ALU forms an address, an arithmetic result or an equality test. The rising edge that closes the cycle then updates the program counter, the register file and, for a store, the data memory.

Both memories live outside the core and are read combinationally. The instruction port returns the word at the presented address in the same cycle. The data port returns read data in the same cycle and takes a write strobe that the memory acts on at the next rising edge. Any opcode outside the supported slice retires as a no-op that only moves the program counter forward by four.

Top module: `rvs_core`

## Requirements
- R1: A synchronous active-high reset forces the program counter, and so `imem_addr`, to 0x00000000. While reset is high, neither the data memory nor the register file is written.
- R2: Opcode 0110011 with funct3 000 writes rs1+rs2 to rd when funct7 is 0000000, and rs1-rs2 when funct7 is 0100000, with 32-bit wraparound.
- R3: Opcode 0110011 writes rs1 AND rs2 to rd when funct3 is 111, and rs1 OR rs2 to rd when funct3 is 110, with funct7 0000000.
- R4: Opcode 0000011 (load word) places rs1 plus the sign-extended I-immediate (bits 31:20) on `dmem_addr`, raises `dmem_re`, and writes `dmem_rdata` to rd. `dmem_re` is high for no other instruction.
- R5: Opcode 0100011 (store word) places rs1 plus the sign-extended S-immediate (bits 31:25 over 11:7) on `dmem_addr` and rs2 on `dmem_wdata`, and raises `dmem_we`. It writes no register. `dmem_we` is high for no other instruction.
- R6: For opcode 1100011 (branch-if-equal), the ALU subtracts rs2 from rs1. When the result is zero, the next PC is PC plus the sign-extended B-immediate, with bit 12 from bit 31, bit 11 from bit 7, bits 10:5 from bits 30:25, bits 4:1 from bits 11:8, and bit 0 zero. This covers negative offsets. Otherwise the next PC is PC+4.
- R7: Register x0 reads as zero, and writes aimed at it are discarded.
- R8: Any other opcode, or an R-type funct3/funct7 pair not listed in R2 and R3, changes no register and no memory, and advances the PC by 4.
- R9: Every instruction completes in one cycle. A result written by one instruction is visible to the instruction that follows it, and a stored word can be loaded by the next instruction.
- R10: Every instruction other than a taken branch advances the PC by exactly 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data (rs2) |
| dmem_re | output | 1 | Load in progress |
| dmem_we | output | 1 | Store strobe, memory writes at the next rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, same cycle |

## Verification
Register contents cannot be seen at the ports, so every result is brought out by a following store. The program therefore interleaves stores after each computation. Store address, store data, load strobe and PC are predicted cycle by cycle. The hardest cases to reach are a write to x0, which shows up only when x0 is later stored and yields zero, and a disguised unsupported instruction, which is decoded as an add-immediate that would overwrite x1 if it were executed. A backward branch with a negative offset forms a short loop, so that sign extension of the B-immediate is exercised over two passes. A load from a word the program has just stored, addressed with a negative offset, covers same-cycle completion and I-immediate sign extension together.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_OR  = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    mem_read;
    logic    mem_write;
    logic    b_from_imm;
    logic    imm_is_store;
    logic    wb_from_mem;
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;

  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_RTYPE  = 7'b0110011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;

endpackage

// File: rtl/rvs_ctrl_decode.sv
module rvs_ctrl_decode
  import rvs_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  input  logic [6:0] funct7,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    unique case (opcode)
      OPC_LOAD: begin
        ctrl.reg_write   = 1'b1;
        ctrl.mem_read    = 1'b1;
        ctrl.b_from_imm  = 1'b1;
        ctrl.wb_from_mem = 1'b1;
      end
      OPC_STORE: begin
        ctrl.mem_write    = 1'b1;
        ctrl.b_from_imm   = 1'b1;
        ctrl.imm_is_store = 1'b1;
      end
      OPC_BRANCH: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OPC_RTYPE: begin
        if (funct3 == 3'b000 && funct7 == F7_BASE) begin
          ctrl.reg_write = 1'b1;
          ctrl.alu_op    = ALU_ADD;
        end else if (funct3 == 3'b000 && funct7 == F7_ALT) begin
          ctrl.reg_write = 1'b1;
          ctrl.alu_op    = ALU_SUB;
        end else if (funct3 == 3'b111 && funct7 == F7_BASE) begin
          ctrl.reg_write = 1'b1;
          ctrl.alu_op    = ALU_AND;
        end else if (funct3 == 3'b110 && funct7 == F7_BASE) begin
          ctrl.reg_write = 1'b1;
          ctrl.alu_op    = ALU_OR;
        end
      end
      default: ctrl = ctrl;
    endcase
  end

endmodule

// File: rtl/rvs_imm_gen.sv
module rvs_imm_gen #(
  parameter int XLEN = 32
) (
  input  logic [11:0]     hi12,
  input  logic [4:0]      lo5,
  output logic [XLEN-1:0] imm_i,
  output logic [XLEN-1:0] imm_s,
  output logic [XLEN-1:0] imm_b
);

  localparam int EXT_I = XLEN - 12;
  localparam int EXT_B = XLEN - 13;

  always_comb begin
    imm_i = {{EXT_I{hi12[11]}}, hi12};
    imm_s = {{EXT_I{hi12[11]}}, hi12[11:5], lo5};
    imm_b = {{EXT_B{hi12[11]}}, hi12[11], lo5[0], hi12[10:5], lo5[4:1], 1'b0};
  end

endmodule

// File: rtl/rvs_alu.sv
module rvs_alu
  import rvs_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y,
  output logic            zero
);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      default: y = '0;
    endcase
    zero = (y == '0);
  end

endmodule

// File: rtl/rvs_regfile.sv
module rvs_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   ra1,
  input  logic [AW-1:0]   ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2
);

  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) regs[waddr] <= wdata;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/rvs_core.sv
module rvs_core
  import rvs_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          NREG     = 32,
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_re,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);

  localparam int AW = $clog2(NREG);

  logic [XLEN-1:0] pc_q, pc_next, pc_plus4, pc_target;
  logic [XLEN-1:0] imm_i, imm_s, imm_b;
  logic [XLEN-1:0] rs1_val, rs2_val, alu_b, alu_y, wb_val;
  logic            alu_zero, take_branch, rf_we;
  ctrl_t           ctrl;

  wire [6:0] f_opc = imem_rdata[6:0];
  wire [4:0] f_rd  = imem_rdata[11:7];
  wire [2:0] f_f3  = imem_rdata[14:12];
  wire [4:0] f_rs1 = imem_rdata[19:15];
  wire [4:0] f_rs2 = imem_rdata[24:20];
  wire [6:0] f_f7  = imem_rdata[31:25];

  rvs_ctrl_decode u_dec (
    .opcode (f_opc),
    .funct3 (f_f3),
    .funct7 (f_f7),
    .ctrl   (ctrl)
  );

  rvs_imm_gen #(.XLEN(XLEN)) u_imm (
    .hi12  (imem_rdata[31:20]),
    .lo5   (imem_rdata[11:7]),
    .imm_i (imm_i),
    .imm_s (imm_s),
    .imm_b (imm_b)
  );

  rvs_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk   (clk),
    .we    (rf_we),
    .waddr (f_rd[AW-1:0]),
    .wdata (wb_val),
    .ra1   (f_rs1[AW-1:0]),
    .ra2   (f_rs2[AW-1:0]),
    .rd1   (rs1_val),
    .rd2   (rs2_val)
  );

  // operand B steering: register or immediate
  assign alu_b = ctrl.b_from_imm ? (ctrl.imm_is_store ? imm_s : imm_i) : rs2_val;

  rvs_alu #(.XLEN(XLEN)) u_alu (
    .a    (rs1_val),
    .b    (alu_b),
    .op   (ctrl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // writeback steering
  assign wb_val = ctrl.wb_from_mem ? dmem_rdata : alu_y;
  assign rf_we  = ctrl.reg_write & ~rst;

  // next-PC steering
  assign take_branch = ctrl.branch & alu_zero;
  assign pc_plus4    = pc_q + XLEN'(4);
  assign pc_target   = pc_q + imm_b;
  assign pc_next     = take_branch ? pc_target : pc_plus4;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC[XLEN-1:0];
    else     pc_q <= pc_next;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rs2_val;
  assign dmem_re    = ctrl.mem_read & ~rst;
  assign dmem_we    = ctrl.mem_write & ~rst;

  // R4 R5
  mem_rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(dmem_re && dmem_we));

  // R5
  store_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> !rf_we);

  // R6
  branch_no_side_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.branch |-> (!rf_we && !dmem_we && !dmem_re));

  // R10
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !take_branch |=> imem_addr == $past(imem_addr) + XLEN'(4));

  // R4
  load_wb_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_re |-> (rf_we && wb_val == dmem_rdata));

endmodule

// File: tb/rvs_core_test.sv
`timescale 1ns/1ps
module rvs_core_test;

  localparam int IWORDS = 32;
  localparam int DWORDS = 32;

  typedef struct {
    logic [31:0] pc;
    bit          st;
    bit          ld;
    logic [31:0] addr;
    logic [31:0] data;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_re, dmem_we;

  logic [31:0] imem [IWORDS];
  logic [31:0] dmem [DWORDS];

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   run    = 1'b0;
  bit   done   = 1'b0;

  always #10 clk = ~clk;

  rvs_core uut (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_re    (dmem_re),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[6:2]];
  assign dmem_rdata = dmem[dmem_addr[6:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[6:2]] <= dmem_wdata;

  function automatic logic [31:0] op_r(input logic [6:0] f7, input logic [4:0] rs2,
                                       input logic [4:0] rs1, input logic [2:0] f3,
                                       input logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'b0110011};
  endfunction

  function automatic logic [31:0] op_lw(input logic [11:0] imm, input logic [4:0] rs1,
                                        input logic [4:0] rd);
    return {imm, rs1, 3'b010, rd, 7'b0000011};
  endfunction

  function automatic logic [31:0] op_sw(input logic [11:0] imm, input logic [4:0] rs2,
                                        input logic [4:0] rs1);
    return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], 7'b0100011};
  endfunction

  function automatic logic [31:0] op_beq(input logic [12:0] imm, input logic [4:0] rs1,
                                         input logic [4:0] rs2);
    return {imm[12], imm[10:5], rs2, rs1, 3'b000, imm[4:1], imm[11], 7'b1100011};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] pc, input bit st, input bit ld,
                      input logic [31:0] addr, input logic [31:0] data, input string req);
    exp_t e;
    e.pc = pc; e.st = st; e.ld = ld; e.addr = addr; e.data = data; e.req = req;
    q.push_back(e);
  endtask

  task automatic step(input logic [31:0] pc, input string req);
    push(pc, 1'b0, 1'b0, 32'h0, 32'h0, req);
  endtask

  // monitor: pops one expected item per executed instruction
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (run && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.req, "pc", imem_addr, e.pc);
        check(e.req, "store strobe", {31'b0, dmem_we}, {31'b0, e.st});
        check(e.req, "load strobe", {31'b0, dmem_re}, {31'b0, e.ld});
        if (e.st) begin
          check(e.req, "store addr", dmem_addr, e.addr);
          check(e.req, "store data", dmem_wdata, e.data);
        end
        if (e.ld) check(e.req, "load addr", dmem_addr, e.addr);
      end
    end
  end

  // driver
  initial begin
    for (int i = 0; i < IWORDS; i++) imem[i] = 32'h0;
    for (int i = 0; i < DWORDS; i++) dmem[i] = 32'h0;
    dmem[0] = 32'h0000_0015;
    dmem[1] = 32'hFFFF_FFF0;
    dmem[2] = 32'h0F0F_00FF;

    imem[0]  = op_lw(12'd0, 5'd0, 5'd1);
    imem[1]  = op_lw(12'd4, 5'd0, 5'd2);
    imem[2]  = op_r(7'b0000000, 5'd2, 5'd1, 3'b000, 5'd3);
    imem[3]  = op_sw(12'd32, 5'd3, 5'd0);
    imem[4]  = op_r(7'b0100000, 5'd2, 5'd1, 3'b000, 5'd4);
    imem[5]  = op_sw(12'd36, 5'd4, 5'd0);
    imem[6]  = op_lw(12'd8, 5'd0, 5'd5);
    imem[7]  = op_r(7'b0000000, 5'd2, 5'd5, 3'b111, 5'd6);
    imem[8]  = op_r(7'b0000000, 5'd1, 5'd6, 3'b110, 5'd7);
    imem[9]  = op_sw(12'd40, 5'd6, 5'd0);
    imem[10] = op_sw(12'd44, 5'd7, 5'd0);
    imem[11] = op_r(7'b0000000, 5'd1, 5'd1, 3'b000, 5'd0);
    imem[12] = op_sw(12'd48, 5'd0, 5'd0);
    imem[13] = op_beq(13'd8, 5'd1, 5'd2);
    imem[14] = 32'h0630_0093;
    imem[15] = op_beq(13'd12, 5'd3, 5'd3);
    imem[16] = op_sw(12'd52, 5'd1, 5'd0);
    imem[17] = op_sw(12'd52, 5'd1, 5'd0);
    imem[18] = op_sw(12'd56, 5'd1, 5'd0);
    imem[19] = op_lw(12'hFFB, 5'd4, 5'd9);
    imem[20] = op_r(7'b0100000, 5'd3, 5'd9, 3'b000, 5'd10);
    imem[21] = op_sw(12'd60, 5'd10, 5'd0);
    imem[22] = op_beq(13'd8, 5'd10, 5'd0);
    imem[23] = op_sw(12'd0, 5'd1, 5'd0);
    imem[24] = op_beq(13'h1FF4, 5'd0, 5'd0);

    // expected trace
    push(32'h00, 0, 1, 32'd0, 0, "R4");
    push(32'h04, 0, 1, 32'd4, 0, "R4");
    step(32'h08, "R10");
    push(32'h0C, 1, 0, 32'd32, 32'h0000_0005, "R2");
    step(32'h10, "R10");
    push(32'h14, 1, 0, 32'd36, 32'h0000_0025, "R2");
    push(32'h18, 0, 1, 32'd8, 0, "R4");
    step(32'h1C, "R3");
    step(32'h20, "R3");
    push(32'h24, 1, 0, 32'd40, 32'h0F0F_00F0, "R3");
    push(32'h28, 1, 0, 32'd44, 32'h0F0F_00F5, "R3");
    step(32'h2C, "R7");
    push(32'h30, 1, 0, 32'd48, 32'h0, "R7");
    step(32'h34, "R6");
    step(32'h38, "R6");
    step(32'h3C, "R8");
    push(32'h48, 1, 0, 32'd56, 32'h0000_0015, "R8");
    push(32'h4C, 0, 1, 32'd32, 0, "R9");
    step(32'h50, "R9");
    push(32'h54, 1, 0, 32'd60, 32'h0, "R9");
    step(32'h58, "R6");
    step(32'h60, "R6");
    push(32'h54, 1, 0, 32'd60, 32'h0, "R6");
    step(32'h58, "R6");
    step(32'h60, "R6");

    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    check("R1", "pc in reset", imem_addr, 32'h0);
    check("R1", "store strobe in reset", {31'b0, dmem_we}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    run = 1'b1;

    wait (q.size() == 0);
    @(negedge clk);
    run = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    check("R1", "pc after mid-run reset", imem_addr, 32'h0);
    check("R7", "stored x0 word", dmem[12], 32'h0);
    check("R8", "skipped store word", dmem[13], 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // watchdog
  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule